// File: doc/BRIEF.md
# Read-Address Sequence Command Detector

This block sits beside the host port of a memory device and watches the stream of accesses. It recognizes a hidden command that the host issues by reading six particular addresses back to back. The first five addresses form a common prefix. The sixth address chooses one of three commands: commit the working array to the persistent array, reload the working array from the persistent array, or turn off the automatic commit that normally runs on power loss. When a full run is seen, the block emits a one-cycle pulse with a two-bit command code. A separate engine carries out the command.

Any write, or any read at an address that does not fit the next step, cancels the run in progress. Cycles with no access leave the progress unchanged. Only a thirteen-bit slice of the address takes part in the comparison. A host can therefore hit the pattern at any alias outside that slice. An access counts when either the chip-enable strobe or the output-enable strobe marks it. While the command engine is busy, it asserts an inhibit input, and the detector stays idle.

Top module: `rdseq_cmd_detect`

## Requirements
- R1: Synchronous reset (rst high) clears all progress. cmdValid and cmdCode are 0 in the cycle after reset, and a run that was in progress before reset cannot complete afterwards.
- R2: Reads at prefix addresses 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F in that order, followed by a read at 0x8FC0, make cmdValid high with cmdCode=1 (commit) in the cycle after the sixth access is sampled.
- R3: The same prefix followed by a read at 0x4C63 gives cmdCode=2 (reload).
- R4: The same prefix followed by a read at 0x8B45 gives cmdCode=3 (auto-commit off).
- R5: A read whose address fits neither the next step nor the first prefix address cancels the run, and finishing the remaining steps then produces no pulse.
- R6: A write (accWrite=1) at any step cancels the run, even at the address the next step expects. A write never produces a pulse.
- R7: Only address bits 14 down to 2 are compared. Flipping bits 1:0 or 18:15 of any access does not change the result, and flipping any bit in 14:2 of the sixth access prevents the pulse.
- R8: An access is a cycle in which accCe or accOe is high, or both, and it counts once. A cycle with neither strobe high leaves the progress untouched and produces no pulse.
- R9: A cancelling read at the first prefix address (0x4E38) restarts the run at step two. The next four prefix reads plus a trigger read then complete a command.
- R10: cmdValid lasts exactly one cycle and cmdCode is 0 whenever cmdValid is low. After a pulse the detector is idle, so a lone trigger read does nothing.
- R11: While inhibit is high, the progress is cleared and no pulse is produced. An access sampled with inhibit high never completes a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inhibit | input | 1 | Holds the detector idle while a transfer runs |
| accCe | input | 1 | Access strobe, chip-enable controlled |
| accOe | input | 1 | Access strobe, output-enable controlled |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accAddr | input | 19 | Access address |
| cmdValid | output | 1 | One-cycle command pulse |
| cmdCode | output | 2 | 1 commit, 2 reload, 3 auto-commit off, 0 otherwise |

## Verification
The hardest case to reach is a cancel that lands deep in a run. The most delicate version is a read of the first prefix address arriving after five good steps, which has to leave the detector at step two rather than idle. The stimulus reaches every such state directly. It sweeps the cancel position over steps one to five, for each trigger and for both kinds of cancel (a stray read and a write at the expected address). It then feeds the remaining steps and confirms that no pulse follows. Single-bit sweeps over the full address width separate the compared slice from the ignored bits.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_COMMIT = 2'd1,
    CMD_RELOAD = 2'd2,
    CMD_ACOFF  = 2'd3
  } cmd_e;

  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic advance;
    logic restart;
    logic clear;
    logic fire;
  } seqCtrl_t;

  localparam int unsigned PREFIX_LEN = 5;
  localparam int unsigned NUM_TRIG   = 3;
  localparam int unsigned SEQ_LEN    = PREFIX_LEN + 1;

  function automatic logic [15:0] prefixKey(input int unsigned idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  // trigger index i selects command code i+1
  function automatic logic [15:0] trigKey(input int unsigned idx);
    case (idx)
      0:       return 16'h8FC0;
      1:       return 16'h4C63;
      default: return 16'h8B45;
    endcase
  endfunction

endpackage

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
  import rdseq_pkg::*;
#(
  parameter int unsigned STEP_W = $clog2(SEQ_LEN)
) (
  input  logic              inhibit,
  input  logic              accCe,
  input  logic              accOe,
  input  logic              accWrite,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic              prefixHit,
  input  logic              firstHit,
  input  logic              trigValid,
  output seqCtrl_t          ctrl
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

  logic accPresent;
  assign accPresent = accCe | accOe;

  always_comb begin
    ctrl = '0;
    if (inhibit) begin
      ctrl.clear = 1'b1;
    end else if (accPresent) begin
      if (accWrite) begin
        ctrl.clear = 1'b1;
      end else if (stepIdx == LAST_STEP) begin
        if (trigValid) begin
          ctrl.fire  = 1'b1;
          ctrl.clear = 1'b1;
        end else if (firstHit) begin
          ctrl.restart = 1'b1;
        end else begin
          ctrl.clear = 1'b1;
        end
      end else if (prefixHit) begin
        ctrl.advance = 1'b1;
      end else if (firstHit) begin
        ctrl.restart = 1'b1;
      end else begin
        ctrl.clear = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rdseq_datapath.sv
module rdseq_datapath
  import rdseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned CMP_LO = 2,
  parameter int unsigned CMP_HI = 14,
  parameter int unsigned STEP_W = $clog2(SEQ_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] accAddr,
  input  seqCtrl_t          ctrl,
  output logic [STEP_W-1:0] stepIdx,
  output logic              prefixHit,
  output logic              firstHit,
  output logic              trigValid,
  output logic              cmdValid,
  output cmd_e              cmdCode
);

  localparam int unsigned CMP_W = CMP_HI - CMP_LO + 1;

  logic [CMP_W-1:0] addrField;
  assign addrField = accAddr[CMP_HI:CMP_LO];

  logic unusedAddrBits;
  assign unusedAddrBits = ^{accAddr[ADDR_W-1:CMP_HI+1], accAddr[CMP_LO-1:0]};

  logic [PREFIX_LEN-1:0] keyHit;
  logic [NUM_TRIG-1:0]   trigHit;

  for (genvar gi = 0; gi < PREFIX_LEN; gi++) begin : g_prefix
    localparam logic [15:0] KEY = prefixKey(gi);
    assign keyHit[gi] = (addrField == KEY[CMP_HI:CMP_LO]);
  end

  for (genvar gt = 0; gt < NUM_TRIG; gt++) begin : g_trig
    localparam logic [15:0] KEY = trigKey(gt);
    assign trigHit[gt] = (addrField == KEY[CMP_HI:CMP_LO]);
  end

  assign firstHit  = keyHit[0];
  assign trigValid = |trigHit;

  always_comb begin
    prefixHit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (stepIdx == STEP_W'(i)) prefixHit = keyHit[i];
    end
  end

  cmd_e trigCode;
  always_comb begin
    trigCode = CMD_NONE;
    for (int i = NUM_TRIG - 1; i >= 0; i--) begin
      if (trigHit[i]) trigCode = cmd_e'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepIdx <= '0;
    end else if (ctrl.clear) begin
      stepIdx <= '0;
    end else if (ctrl.restart) begin
      stepIdx <= STEP_W'(1);
    end else if (ctrl.advance) begin
      stepIdx <= stepIdx + STEP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdValid <= 1'b0;
      cmdCode  <= CMD_NONE;
    end else begin
      cmdValid <= ctrl.fire;
      cmdCode  <= ctrl.fire ? trigCode : CMD_NONE;
    end
  end

endmodule

// File: rtl/rdseq_cmd_detect.sv
module rdseq_cmd_detect
  import rdseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned CMP_LO = 2,
  parameter int unsigned CMP_HI = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inhibit,
  input  logic              accCe,
  input  logic              accOe,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              cmdValid,
  output logic [1:0]        cmdCode
);

  localparam int unsigned STEP_W = $clog2(SEQ_LEN);

  seqCtrl_t          ctrl;
  logic [STEP_W-1:0] stepIdx;
  logic              prefixHit;
  logic              firstHit;
  logic              trigValid;
  cmd_e              cmdCodeE;

  rdseq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .inhibit  (inhibit),
    .accCe    (accCe),
    .accOe    (accOe),
    .accWrite (accWrite),
    .stepIdx  (stepIdx),
    .prefixHit(prefixHit),
    .firstHit (firstHit),
    .trigValid(trigValid),
    .ctrl     (ctrl)
  );

  rdseq_datapath #(
    .ADDR_W(ADDR_W),
    .CMP_LO(CMP_LO),
    .CMP_HI(CMP_HI),
    .STEP_W(STEP_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .accAddr  (accAddr),
    .ctrl     (ctrl),
    .stepIdx  (stepIdx),
    .prefixHit(prefixHit),
    .firstHit (firstHit),
    .trigValid(trigValid),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCodeE)
  );

  assign cmdCode = cmdCodeE;

endmodule

// File: rtl/rdseq_cmd_detect_chk.sv
module rdseq_cmd_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       inhibit,
  input logic       accCe,
  input logic       accOe,
  input logic       accWrite,
  input logic       cmdValid,
  input logic [1:0] cmdCode
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !cmdValid);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> !cmdValid);

  // R10
  code_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cmdValid |-> (cmdCode == 2'd0));

  // R2
  code_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> (cmdCode != 2'd0));

  // R6
  write_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    ((accCe || accOe) && accWrite) |=> !cmdValid);

  // R8
  noacc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(accCe || accOe) |=> !cmdValid);

  // R11
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !cmdValid);

endmodule

bind rdseq_cmd_detect rdseq_cmd_detect_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .inhibit (inhibit),
  .accCe   (accCe),
  .accOe   (accOe),
  .accWrite(accWrite),
  .cmdValid(cmdValid),
  .cmdCode (cmdCode)
);

// File: tb/sim_rdseq_cmd_detect.sv
`timescale 1ns/1ps
module sim_rdseq_cmd_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inhibit = 1'b0;
  logic        accCe = 1'b0;
  logic        accOe = 1'b0;
  logic        accWrite = 1'b0;
  logic [18:0] accAddr = '0;
  logic        cmdValid;
  logic [1:0]  cmdCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rdseq_cmd_detect u0 (
    .clk(clk), .rst(rst), .inhibit(inhibit), .accCe(accCe), .accOe(accOe),
    .accWrite(accWrite), .accAddr(accAddr), .cmdValid(cmdValid), .cmdCode(cmdCode)
  );

  function automatic logic [18:0] keyAddr(input int step, input int cmd);
    case (step)
      0: return 19'h04E38;
      1: return 19'h0B1C7;
      2: return 19'h083E0;
      3: return 19'h07C1F;
      4: return 19'h0703F;
      default: case (cmd)
        1: return 19'h08FC0;
        2: return 19'h04C63;
        default: return 19'h08B45;
      endcase
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectOut(input string req, input int expValid, input int expCode);
    check(cmdValid == expValid[0], req, cmdValid, expValid);
    check(cmdCode == expCode[1:0], req, cmdCode, expCode);
  endtask

  // one access; returns at the negedge where its result is visible
  task automatic access(input logic [18:0] a, input logic wr, input int mode);
    @(negedge clk);
    accAddr  = a;
    accWrite = wr;
    accCe    = (mode != 1);
    accOe    = (mode != 0);
    @(negedge clk);
    accCe = 1'b0; accOe = 1'b0; accWrite = 1'b0;
  endtask

  task automatic prefix(input int upto, input logic [18:0] xm, input int mode);
    for (int s = 0; s < upto; s++) access(keyAddr(s, 1) ^ xm, 1'b0, mode);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    expectOut("R1 reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    expectOut("R1 after reset", 0, 0);

    // R2 R3 R4 R8 R10: every command under each strobe mode
    for (int cmd = 1; cmd <= 3; cmd++) begin
      for (int mode = 0; mode < 3; mode++) begin
        for (int s = 0; s < 5; s++) begin
          access(keyAddr(s, cmd), 1'b0, mode);
          expectOut("R10 no pulse mid run", 0, 0);
        end
        repeat (3) @(negedge clk); // idle cycles do not cancel (R8)
        access(keyAddr(5, cmd), 1'b0, mode);
        expectOut(cmd == 1 ? "R2 commit" : (cmd == 2 ? "R3 reload" : "R4 acoff"), 1, cmd);
        @(negedge clk);
        expectOut("R10 one cycle pulse", 0, 0);
      end
    end

    // R10 lone trigger after a command does nothing
    access(keyAddr(5, 2), 1'b0, 0);
    expectOut("R10 idle after pulse", 0, 0);

    // R5 R6: cancel at every step with a stray read or a write
    for (int cmd = 1; cmd <= 3; cmd++) begin
      for (int k = 1; k <= 5; k++) begin
        for (int kind = 0; kind < 2; kind++) begin
          prefix(k, '0, 0);
          if (kind == 0) access(19'h00004, 1'b0, 0);
          else           access(keyAddr(k, cmd), 1'b1, 0);
          expectOut(kind == 0 ? "R5 cancel read" : "R6 cancel write", 0, 0);
          for (int s = k; s <= 5; s++) access(keyAddr(s, cmd), 1'b0, 2);
          expectOut(kind == 0 ? "R5 no cmd after cancel" : "R6 no cmd after write", 0, 0);
        end
      end
    end

    // R6 write at trigger address
    prefix(5, '0, 1);
    access(keyAddr(5, 1), 1'b1, 1);
    expectOut("R6 write trigger", 0, 0);

    // R7 ignored bits
    for (int b = 0; b < 19; b++) begin
      if (b < 2 || b > 14) begin
        prefix(5, 19'(1) << b, 0);
        access(keyAddr(5, 3) ^ (19'(1) << b), 1'b0, 0);
        expectOut("R7 ignored bit", 1, 3);
      end else begin
        prefix(5, '0, 0);
        access(keyAddr(5, 3) ^ (19'(1) << b), 1'b0, 0);
        expectOut("R7 compared bit", 0, 0);
      end
    end

    // R9 restart at step two from several depths
    for (int k = 1; k <= 5; k++) begin
      prefix(k, '0, 0);
      access(keyAddr(0, 1), 1'b0, 0);
      for (int s = 1; s <= 5; s++) access(keyAddr(s, 2), 1'b0, 0);
      expectOut("R9 restart", 1, 2);
    end

    // R11 inhibit pulse mid run clears progress
    prefix(5, '0, 0);
    @(negedge clk); inhibit = 1'b1;
    @(negedge clk); inhibit = 1'b0;
    access(keyAddr(5, 1), 1'b0, 0);
    expectOut("R11 cleared by inhibit", 0, 0);
    // R11 inhibit during the trigger access
    prefix(5, '0, 0);
    @(negedge clk); inhibit = 1'b1;
    access(keyAddr(5, 1), 1'b0, 0);
    expectOut("R11 suppressed", 0, 0);
    @(negedge clk); inhibit = 1'b0;
    prefix(5, '0, 0);
    access(keyAddr(5, 1), 1'b0, 0);
    expectOut("R11 works after release", 1, 1);

    // R1 reset mid run
    prefix(5, '0, 0);
    doReset();
    access(keyAddr(5, 1), 1'b0, 0);
    expectOut("R1 reset clears run", 0, 0);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule